// File: doc/BRIEF.md
# Push-Pull Two-Wire Bus Master

This block is the serial engine of a two-wire bus that connects to exactly one slave device. Both lines are driven push-pull by the master, so there is no slave address field and no acknowledge phase. A transaction carries one register address byte and then one to eight data bytes. Every byte on the wire is followed by an even parity bit. For a write, the master drives all bytes. For a read, the master drives the address byte and then releases SDA, so the slave returns the data bytes and their parity bits in the same access.

A start pulse latches the transfer settings and runs a full frame: start condition, bit cells, stop condition. At the end the block raises a one-cycle done pulse and a held error flag. An abort pulse cuts the frame short at the next bit boundary. The SCL half period comes from an 8-bit divider. A 3-bit setting places SDA data changes a fixed number of input clocks after each falling SCL edge. Software override controls can force either line to a chosen level, and the live line levels are brought out for readback.

Top module: `ppbus_master`

## Requirements
- R1: After reset and whenever no frame is in progress, scl_o and sda_o are 1, sda_oe is 1, and busy and done are 0.
- R2: A frame opens with SDA falling while SCL is high and closes with SDA rising while SCL is high. Inside the frame SDA never changes while SCL is high. Each SCL high and low phase lasts `clk_div` input clocks, where 0 counts as 1.
- R3: A write frame carries (len_m1+2) bytes MSB first: reg_addr, then wr_data byte k from bits [8k+7:8k]. Each byte is followed by one parity bit equal to the XOR of its 8 bits. There is no address field and no acknowledge bit, so the frame has exactly 9*(len_m1+2) SCL pulses before the stop.
- R4: When rd_en=1, only the address byte and its parity are driven. For the data bytes sda_oe is 0. Each bit is sampled at the end of its SCL high phase, and data byte k lands in rd_data[8k+7:8k].
- R5: On a read, a received parity bit that differs from the XOR of its byte sets err with done. The data byte is still stored.
- R6: With sda_dly=D (0 counts as 1), a driven SDA change inside a frame occurs exactly D input clocks after the falling SCL edge. This holds when D < clk_div.
- R7: An abort pulse during a frame produces a stop condition after the current bit cell, ends the frame early, and raises done with err=1.
- R8: scl_ovr_en forces scl_o to scl_ovr_val. sda_ovr_en forces sda_o to sda_ovr_val and sets sda_oe. scl_level and sda_level report the live line levels, where sda_level is sda_in when SDA is released.
- R9: A start pulse while busy is ignored: the running frame keeps its latched settings and no second start condition appears.
- R10: done is a single-cycle pulse. err is cleared by the next start and is 0 after a clean transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start pulse, accepted when idle |
| abort | input | 1 | Abort pulse |
| rd_en | input | 1 | 1 selects a read frame |
| len_m1 | input | 3 | Data byte count minus one |
| reg_addr | input | 8 | Register address byte |
| wr_data | input | 64 | Write bytes, byte k in [8k+7:8k] |
| clk_div | input | 8 | SCL half period in input clocks |
| sda_dly | input | 3 | SDA change delay after SCL falls |
| scl_ovr_en | input | 1 | SCL override enable |
| scl_ovr_val | input | 1 | SCL override level |
| sda_ovr_en | input | 1 | SDA override enable |
| sda_ovr_val | input | 1 | SDA override level |
| sda_in | input | 1 | Sampled SDA line |
| scl_o | output | 1 | SCL drive |
| sda_o | output | 1 | SDA drive value |
| sda_oe | output | 1 | SDA drive enable |
| scl_level | output | 1 | Live SCL level |
| sda_level | output | 1 | Live SDA level |
| busy | output | 1 | Frame in progress |
| done | output | 1 | End-of-frame pulse |
| err | output | 1 | Parity or abort error of last frame |
| rd_data | output | 64 | Received bytes, byte k in [8k+7:8k] |

## Verification
The bench sweeps every transfer length in both directions over three divider and delay pairs. One pair has a delay of zero, to show that it counts as one. Byte values alternate between arithmetic sequences and the extremes 00, FF, 01 and 80, so bit order and the value of every parity bit can be told apart. Separate frames corrupt a returned parity bit, raise abort in mid-frame, and repeat the start pulse while busy. These cases separate parity checking, early termination and settings capture from the normal path. A final idle check forces each line through the override controls and reads the levels back.

// File: rtl/ppbus_pkg.sv
package ppbus_pkg;
    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned LEN_W     = 3;
    localparam int unsigned MAX_BYTES = 1 << LEN_W;
    localparam int unsigned DIV_W     = 8;
    localparam int unsigned DLY_W     = 3;
    localparam int unsigned IDX_W     = LEN_W + 1;
    localparam int unsigned CELL_BITS = BYTE_W + 1;
    localparam int unsigned BIT_W     = $clog2(CELL_BITS);
    localparam int unsigned BSEL_W    = $clog2(BYTE_W);
    localparam int unsigned DATA_W    = MAX_BYTES * BYTE_W;

    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_LOW, ST_HIGH, ST_STOP_LO, ST_STOP_HI
    } phase_e;

    typedef struct packed {
        logic               rd;
        logic [LEN_W-1:0]   len_m1;
        logic [DIV_W-1:0]   div;
        logic [DLY_W-1:0]   dly;
        logic [BYTE_W-1:0]  addr;
    } xfer_cfg_t;

    function automatic logic even_par(input logic [BYTE_W-1:0] b);
        return ^b;
    endfunction
endpackage

// File: rtl/ppbus_halfclk.sv
module ppbus_halfclk #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic [W-1:0] div,
    output logic         tick
);
    logic [W-1:0] cnt;
    logic [W-1:0] lim;

    assign lim  = (div == '0) ? '0 : div - W'(1);
    assign tick = run && (cnt == lim);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) cnt <= '0;
        else                     cnt <= cnt + W'(1);
    end

    // R2: half-period ticks are spaced by the divider
    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        (tick && lim != '0) |=> !tick);
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt <= lim));
endmodule

// File: rtl/ppbus_sda_drv.sv
module ppbus_sda_drv #(
    parameter int unsigned DW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fall,
    input  logic          tgt,
    input  logic [DW-1:0] dly,
    output logic          sda_q
);
    logic          pend;
    logic [DW-1:0] cnt;
    logic [DW-1:0] dly_ld;

    assign dly_ld = (dly == '0) ? '0 : dly - DW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            sda_q <= 1'b1;
            pend  <= 1'b0;
            cnt   <= '0;
        end else if (fall) begin
            pend <= 1'b1;
            cnt  <= dly_ld;
        end else if (pend) begin
            if (cnt == '0) begin
                sda_q <= tgt;
                pend  <= 1'b0;
            end else begin
                cnt <= cnt - DW'(1);
            end
        end else begin
            sda_q <= tgt;
        end
    end

    // R6: a pending change never outlives the programmed delay
    a_r6_pend_bounded: assert property (@(posedge clk) disable iff (rst)
        (pend && cnt == '0) |=> !pend || $past(fall));
endmodule

// File: rtl/ppbus_seq.sv
module ppbus_seq
    import ppbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic              abort,
    input  logic              tick,
    input  logic              sda_in,
    input  xfer_cfg_t         cfg_in,
    input  logic [DATA_W-1:0] wr_data,
    output logic              busy,
    output logic              scl_eng,
    output logic              sda_tgt,
    output logic              sda_oe_eng,
    output logic              fall,
    output logic              in_bits,
    output logic              done,
    output logic              err,
    output logic [DIV_W-1:0]  div_q,
    output logic [DLY_W-1:0]  dly_q,
    output logic [DATA_W-1:0] rd_data
);
    phase_e            st;
    xfer_cfg_t         cfg_q;
    logic [BYTE_W-1:0] wbuf [MAX_BYTES];
    logic [BYTE_W-1:0] rbuf [MAX_BYTES];
    logic [IDX_W-1:0]  byte_idx;
    logic [BIT_W-1:0]  bit_idx;
    logic [BYTE_W-1:0] rx;
    logic [BYTE_W-1:0] cur_byte;
    logic              abort_p;
    logic              perr;
    logic              rd_phase;
    logic              cell_bit;
    logic              last_cell;

    assign div_q   = cfg_q.div;
    assign dly_q   = cfg_q.dly;
    assign busy    = (st != ST_IDLE);
    assign in_bits = (st == ST_LOW) || (st == ST_HIGH);
    assign fall    = tick && ((st == ST_START) || (st == ST_HIGH));

    for (genvar g = 0; g < MAX_BYTES; g++) begin : g_pack
        assign rd_data[g*BYTE_W +: BYTE_W] = rbuf[g];
    end

    always_comb begin
        cur_byte = cfg_q.addr;
        for (int k = 0; k < MAX_BYTES; k++) begin
            if (byte_idx == IDX_W'(k + 1)) cur_byte = wbuf[k];
        end
    end

    assign rd_phase  = cfg_q.rd && (byte_idx != '0);
    assign cell_bit  = (bit_idx < BIT_W'(BYTE_W))
                     ? cur_byte[BSEL_W'(BYTE_W - 1) - bit_idx[BSEL_W-1:0]]
                     : even_par(cur_byte);
    assign last_cell = (bit_idx == BIT_W'(CELL_BITS - 1))
                     && (byte_idx == IDX_W'(cfg_q.len_m1) + IDX_W'(1));

    always_comb begin
        scl_eng    = 1'b1;
        sda_tgt    = 1'b1;
        sda_oe_eng = 1'b1;
        case (st)
            ST_START:   sda_tgt = 1'b0;
            ST_LOW: begin
                scl_eng    = 1'b0;
                sda_tgt    = rd_phase ? 1'b1 : cell_bit;
                sda_oe_eng = !rd_phase;
            end
            ST_HIGH: begin
                sda_tgt    = rd_phase ? 1'b1 : cell_bit;
                sda_oe_eng = !rd_phase;
            end
            ST_STOP_LO: begin
                scl_eng = 1'b0;
                sda_tgt = 1'b0;
            end
            ST_STOP_HI: sda_tgt = 1'b0;
            default:    ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            cfg_q    <= '0;
            byte_idx <= '0;
            bit_idx  <= '0;
            rx       <= '0;
            abort_p  <= 1'b0;
            perr     <= 1'b0;
            done     <= 1'b0;
            err      <= 1'b0;
            for (int k = 0; k < MAX_BYTES; k++) begin
                wbuf[k] <= '0;
                rbuf[k] <= '0;
            end
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: if (go) begin
                    cfg_q    <= cfg_in;
                    for (int k = 0; k < MAX_BYTES; k++)
                        wbuf[k] <= wr_data[k*BYTE_W +: BYTE_W];
                    byte_idx <= '0;
                    bit_idx  <= '0;
                    abort_p  <= 1'b0;
                    perr     <= 1'b0;
                    err      <= 1'b0;
                    st       <= ST_START;
                end
                ST_START: begin
                    if (abort) abort_p <= 1'b1;
                    if (tick)  st <= ST_LOW;
                end
                ST_LOW: begin
                    if (abort) abort_p <= 1'b1;
                    if (tick)  st <= ST_HIGH;
                end
                ST_HIGH: begin
                    if (abort) abort_p <= 1'b1;
                    if (tick) begin
                        if (rd_phase) begin
                            if (bit_idx < BIT_W'(BYTE_W)) begin
                                rx <= {rx[BYTE_W-2:0], sda_in};
                            end else begin
                                for (int k = 0; k < MAX_BYTES; k++)
                                    if (byte_idx == IDX_W'(k + 1)) rbuf[k] <= rx;
                                if (sda_in != even_par(rx)) perr <= 1'b1;
                            end
                        end
                        if (abort_p || last_cell) begin
                            st <= ST_STOP_LO;
                        end else begin
                            st <= ST_LOW;
                            if (bit_idx == BIT_W'(CELL_BITS - 1)) begin
                                bit_idx  <= '0;
                                byte_idx <= byte_idx + IDX_W'(1);
                            end else begin
                                bit_idx <= bit_idx + BIT_W'(1);
                            end
                        end
                    end
                end
                ST_STOP_LO: if (tick) st <= ST_STOP_HI;
                ST_STOP_HI: if (tick) begin
                    st   <= ST_IDLE;
                    done <= 1'b1;
                    err  <= perr | abort_p;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R10: completion is a single-cycle pulse
    a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R9: start pulses during a frame leave the latched settings alone
    a_r9_go_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy && go) |=> $stable(cfg_q));
    // R7: a pending abort ends the frame at the bit boundary
    a_r7_abort_stop: assert property (@(posedge clk) disable iff (rst)
        (st == ST_HIGH && tick && abort_p) |=> (st == ST_STOP_LO));
    // R3: the byte counter never passes the programmed length
    a_r3_byte_limit: assert property (@(posedge clk) disable iff (rst)
        in_bits |-> (byte_idx <= IDX_W'(cfg_q.len_m1) + IDX_W'(1)));
endmodule

// File: rtl/ppbus_master.sv
module ppbus_master
    import ppbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic              abort,
    input  logic              rd_en,
    input  logic [LEN_W-1:0]  len_m1,
    input  logic [BYTE_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic [DLY_W-1:0]  sda_dly,
    input  logic              scl_ovr_en,
    input  logic              scl_ovr_val,
    input  logic              sda_ovr_en,
    input  logic              sda_ovr_val,
    input  logic              sda_in,
    output logic              scl_o,
    output logic              sda_o,
    output logic              sda_oe,
    output logic              scl_level,
    output logic              sda_level,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] rd_data
);
    xfer_cfg_t        cfg_in;
    logic             tick;
    logic             scl_eng;
    logic             sda_tgt;
    logic             sda_oe_eng;
    logic             sda_eng;
    logic             fall;
    logic             in_bits;
    logic [DIV_W-1:0] div_q;
    logic [DLY_W-1:0] dly_q;

    assign cfg_in = '{rd: rd_en, len_m1: len_m1, div: clk_div,
                      dly: sda_dly, addr: reg_addr};

    ppbus_halfclk #(.W(DIV_W)) u_halfclk (
        .clk(clk), .rst(rst), .run(busy), .div(div_q), .tick(tick)
    );

    ppbus_seq u_seq (
        .clk(clk), .rst(rst), .go(go), .abort(abort), .tick(tick),
        .sda_in(sda_in), .cfg_in(cfg_in), .wr_data(wr_data),
        .busy(busy), .scl_eng(scl_eng), .sda_tgt(sda_tgt),
        .sda_oe_eng(sda_oe_eng), .fall(fall), .in_bits(in_bits),
        .done(done), .err(err), .div_q(div_q), .dly_q(dly_q),
        .rd_data(rd_data)
    );

    ppbus_sda_drv #(.DW(DLY_W)) u_sda_drv (
        .clk(clk), .rst(rst), .fall(fall), .tgt(sda_tgt),
        .dly(dly_q), .sda_q(sda_eng)
    );

    assign scl_o     = scl_ovr_en ? scl_ovr_val : scl_eng;
    assign sda_o     = sda_ovr_en ? sda_ovr_val : sda_eng;
    assign sda_oe    = sda_ovr_en | sda_oe_eng;
    assign scl_level = scl_o;
    assign sda_level = sda_oe ? sda_o : sda_in;

    // R2: engine SDA holds steady through every SCL high phase of a bit cell
    a_r2_sda_steady_high: assert property (@(posedge clk) disable iff (rst)
        (in_bits && $past(in_bits) && scl_eng && $past(scl_eng))
        |-> $stable(sda_eng));
    // R1: both engine lines rest high between frames
    a_r1_idle_high: assert property (@(posedge clk) disable iff (rst)
        (!busy && $past(!busy)) |-> (scl_eng && sda_eng && sda_oe_eng));
endmodule

// File: tb/sim_ppbus_master.sv
module sim_ppbus_master;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        go = 1'b0, abort = 1'b0, rd_en = 1'b0;
    logic [2:0]  len_m1 = '0;
    logic [7:0]  reg_addr = '0;
    logic [63:0] wr_data = '0;
    logic [7:0]  clk_div = 8'd2;
    logic [2:0]  sda_dly = 3'd1;
    logic        scl_ovr_en = 1'b0, scl_ovr_val = 1'b0;
    logic        sda_ovr_en = 1'b0, sda_ovr_val = 1'b0;
    logic        sda_in = 1'b1;
    logic        scl_o, sda_o, sda_oe, scl_level, sda_level, busy, done, err;
    logic [63:0] rd_data;

    int checks = 0, errors = 0, cycles = 0;

    ppbus_master u0 (
        .clk(clk), .rst(rst), .go(go), .abort(abort), .rd_en(rd_en),
        .len_m1(len_m1), .reg_addr(reg_addr), .wr_data(wr_data),
        .clk_div(clk_div), .sda_dly(sda_dly), .scl_ovr_en(scl_ovr_en),
        .scl_ovr_val(scl_ovr_val), .sda_ovr_en(sda_ovr_en),
        .sda_ovr_val(sda_ovr_val), .sda_in(sda_in), .scl_o(scl_o),
        .sda_o(sda_o), .sda_oe(sda_oe), .scl_level(scl_level),
        .sda_level(sda_level), .busy(busy), .done(done), .err(err),
        .rd_data(rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // transfer context shared with the slave model
    logic       cur_rd = 1'b0;
    int         cur_len = 0, cur_corrupt = -1, cur_div = 2, cur_deff = 1;
    logic [7:0] cur_addr = '0;
    logic [7:0] wrb [8];
    logic [7:0] rdv [8];

    function automatic logic exp_bit(input int g);
        int b = g / 9;
        int i = g % 9;
        logic [7:0] v;
        logic p;
        v = (b == 0) ? cur_addr : (cur_rd ? rdv[b-1] : wrb[b-1]);
        p = ^v;
        if (cur_rd && b > 0 && (b - 1) == cur_corrupt) p = ~p;
        return (i < 8) ? v[7-i] : p;
    endfunction

    // bus monitor and slave model
    logic prev_scl = 1'b1, prev_sda = 1'b1, prev_oe = 1'b1;
    logic in_frame = 1'b0, had_rise = 1'b0;
    logic bits_seen [128];
    int nrise = 0, n_start = 0, since_rise = 0, since_fall = 0;
    int viol_high = 0, viol_per = 0, viol_dly = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (prev_scl && scl_level && prev_sda && !sda_level) begin
                if (in_frame) viol_high++;
                in_frame = 1'b1; nrise = 0; n_start++; had_rise = 1'b0;
                since_rise = 0; since_fall = 0;
            end else if (prev_scl && scl_level && !prev_sda && sda_level) begin
                in_frame = 1'b0; sda_in = 1'b1;
            end
            if (in_frame) begin
                since_rise++; since_fall++;
                if (!prev_scl && scl_level) begin
                    if (since_fall != cur_div) viol_per++;
                    if (nrise < 128) bits_seen[nrise] = sda_level;
                    nrise++; had_rise = 1'b1; since_rise = 0;
                end
                if (prev_scl && !scl_level) begin
                    if (had_rise && since_rise != cur_div) viol_per++;
                    since_fall = 0;
                    if (cur_rd && nrise >= 9 && nrise < 9*(cur_len+2)) sda_in = exp_bit(nrise);
                    else sda_in = 1'b1;
                end
                if (!scl_level && !prev_scl && sda_oe && prev_oe &&
                    sda_level != prev_sda && since_fall != cur_deff) viol_dly++;
            end
        end
        prev_scl = scl_level; prev_sda = sda_level; prev_oe = sda_oe;
    end

    task automatic check(input logic ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_xfer(input logic rd, input int len, input int dv, input int dl,
                            input int pat, input int corrupt, input int abort_at,
                            input int rego_at);
        int s_start, s_vh, s_vp, s_vd, cyc, mism, full;
        logic got, err_seen;
        cur_rd = rd; cur_len = len; cur_corrupt = corrupt;
        cur_div = dv; cur_deff = (dl == 0) ? 1 : dl;
        cur_addr = 8'((len * 19) + (dv * 5) + (rd ? 128 : 0) + 1);
        for (int k = 0; k < 8; k++) begin
            if (pat == 1) begin
                case (k % 4)
                    0: wrb[k] = 8'h00;
                    1: wrb[k] = 8'hFF;
                    2: wrb[k] = 8'h01;
                    default: wrb[k] = 8'h80;
                endcase
                rdv[k] = ~wrb[k];
            end else begin
                wrb[k] = 8'((k * 53) + (len * 29) + (dv * 7) + 60);
                rdv[k] = 8'((k * 71) + (len * 17) + dv + 165);
            end
        end
        @(negedge clk);
        rd_en = rd; len_m1 = 3'(len); reg_addr = cur_addr;
        clk_div = 8'(dv); sda_dly = 3'(dl);
        for (int k = 0; k < 8; k++) wr_data[k*8 +: 8] = wrb[k];
        s_start = n_start; s_vh = viol_high; s_vp = viol_per; s_vd = viol_dly;
        go = 1'b1;
        cyc = 0; got = 1'b0; err_seen = 1'b0;
        while (!got && cyc < 20000) begin
            @(negedge clk); cyc++;
            go = (cyc == rego_at);
            if (cyc == rego_at) reg_addr = ~cur_addr;
            abort = (cyc == abort_at);
            if (done) begin got = 1'b1; err_seen = err; end
        end
        go = 1'b0; abort = 1'b0;
        check(got, "R10", "done seen", int'(got), 1);
        @(negedge clk);
        check(!done, "R10", "done single pulse", int'(done), 0);
        repeat (3) @(negedge clk);
        full = 9 * (len + 2);
        if (abort_at == 0)
            check(nrise == full + 1, rd ? "R4" : "R3", "pulse count", nrise, full + 1);
        else
            check(nrise > 1 && nrise < full + 1, "R7", "early stop pulses", nrise, full + 1);
        mism = 0;
        for (int g = 0; g < nrise - 1 && g < 127; g++)
            if (bits_seen[g] !== exp_bit(g)) mism++;
        check(mism == 0, rd ? "R4" : "R3", "bit stream mismatches", mism, 0);
        if (rd) begin
            for (int k = 0; k <= len; k++)
                check(rd_data[k*8 +: 8] == rdv[k], "R4", "read byte",
                      int'(rd_data[k*8 +: 8]), int'(rdv[k]));
        end
        check(err_seen == ((corrupt >= 0) || (abort_at != 0)),
              (corrupt >= 0) ? "R5" : ((abort_at != 0) ? "R7" : "R10"),
              "err flag", int'(err_seen), int'((corrupt >= 0) || (abort_at != 0)));
        check(viol_high == s_vh, "R2", "SDA moved under high SCL", viol_high - s_vh, 0);
        check(viol_per == s_vp, "R2", "SCL phase length", viol_per - s_vp, 0);
        check(viol_dly == s_vd, "R6", "SDA delay after fall", viol_dly - s_vd, 0);
        check(n_start - s_start == 1, (rego_at != 0) ? "R9" : "R2", "start conditions",
              n_start - s_start, 1);
        check(scl_level && sda_level && !busy, "R1", "idle after frame",
              int'({scl_level, sda_level, busy}), 6);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles >= 190000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=<190000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 8; k++) begin wrb[k] = '0; rdv[k] = '0; end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(scl_o && sda_o && sda_oe && !busy && !done, "R1", "reset state",
              int'({scl_o, sda_o, sda_oe, busy, done}), 28);

        for (int c = 0; c < 3; c++) begin
            for (int len = 0; len < 8; len++) begin
                for (int rd = 0; rd < 2; rd++) begin
                    case (c)
                        0: run_xfer(rd[0], len, 2, 1, len % 3 == 0 ? 1 : 0, -1, 0, 0);
                        1: run_xfer(rd[0], len, 3, 2, len % 3 == 1 ? 1 : 0, -1, 0, 0);
                        default: run_xfer(rd[0], len, 5, 0, len % 3 == 2 ? 1 : 0, -1, 0, 0);
                    endcase
                end
            end
        end
        // R5: corrupted parity on returned bytes
        run_xfer(1'b1, 3, 2, 1, 0, 2, 0, 0);
        run_xfer(1'b1, 0, 3, 1, 1, 0, 0, 0);
        // R10: clean frame after an error clears err
        run_xfer(1'b1, 1, 2, 1, 0, -1, 0, 0);
        // R7: abort in mid-frame
        run_xfer(1'b0, 7, 2, 1, 0, -1, 60, 0);
        // R9: repeated start while busy
        run_xfer(1'b0, 2, 2, 1, 0, -1, 0, 30);
        // R6: longer delay with a wider divider
        run_xfer(1'b0, 4, 6, 4, 1, -1, 0, 0);

        // R8: overrides and level readback at idle
        @(negedge clk);
        scl_ovr_en = 1'b1; scl_ovr_val = 1'b0;
        #(CLK_PERIOD/4);
        check(!scl_o && !scl_level, "R8", "SCL forced low", int'({scl_o, scl_level}), 0);
        @(negedge clk);
        scl_ovr_en = 1'b0;
        sda_ovr_en = 1'b1; sda_ovr_val = 1'b0;
        #(CLK_PERIOD/4);
        check(!sda_o && sda_oe && !sda_level && scl_o, "R8", "SDA forced low",
              int'({sda_o, sda_oe, sda_level, scl_o}), 5);
        @(negedge clk);
        sda_ovr_val = 1'b1;
        #(CLK_PERIOD/4);
        check(sda_o && sda_level, "R8", "SDA forced high", int'({sda_o, sda_level}), 3);
        @(negedge clk);
        sda_ovr_en = 1'b0;
        #(CLK_PERIOD/4);
        check(scl_o && sda_o && sda_oe, "R8", "release restores idle",
              int'({scl_o, sda_o, sda_oe}), 7);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule